// File: doc/BRIEF.md
# NAND Sector Hamming Parity Generator

This block builds a 24-bit single-error-correcting parity code over one NAND sector while the sector's bytes stream past on an 8-bit or 16-bit data path. Every byte contributes to twelve pairs of parity bits. Three pairs are column parities, formed from the bit index inside a byte. Nine pairs are line parities, formed from the byte address inside the sector. Each pair holds an "even" member, taken over positions whose selecting index bit is 0, and an "odd" member, taken over positions whose index bit is 1. A single flipped data bit therefore changes exactly one member of every pair, and comparing a stored code with a freshly computed one locates the flipped bit.

Software starts a sector with a clear pulse and then holds the enable while data beats arrive. The sector length is programmed in halfword units. After the last byte of the sector has been consumed, the result freezes and a valid flag rises. The code is presented in two forms. The first is a 32-bit word with the even parities in the low half and the odd parities in the high half. The second is a packed 3-byte form ready to write to the spare area.

Top module: `nand_parity_gen`

## Requirements
- R1: After reset, `result_word`, `packed_code` and `result_valid` are all zero.
- R2: Column parities use the byte's bit index b. `result_word[k]` (k = 0, 1, 2) is the XOR of all accepted data bits whose index bit k is 0. `result_word[16+k]` is the XOR of those whose index bit k is 1.
- R3: Line parities use the byte address a within the sector. `result_word[3+j]` (j = 0..8) is the XOR of every bit of every accepted byte whose address bit j is 0. `result_word[19+j]` is the same for address bit j equal to 1. Bits 15:12 and 31:28 stay zero.
- R4: `ecc_clear` zeroes the result, the valid flag and the byte position on the next edge. It takes priority over a beat presented in the same cycle, and the next accepted byte then sits at address 0.
- R5: A beat presented while `ecc_enable` is low, or with `beat_valid` low, changes nothing.
- R6: The sector length is 2*(`sector_hw_m1`+1) bytes. `result_valid` rises on the edge that consumes the last byte. From then until the next clear, further beats change nothing.
- R7: With `wide_mode` high, each beat supplies two bytes. `beat_data[7:0]` is at the lower (even) address and `beat_data[15:8]` is at the next one. With `wide_mode` low, each beat supplies `beat_data[7:0]` only.
- R8: `packed_code[7:0]` is `result_word[7:0]` and `packed_code[15:8]` is `result_word[23:16]`. `packed_code[23:16]` has `result_word[11:8]` in its low nibble and `result_word[27:24]` in its high nibble.
- R9: A sector that differs from an all-zero sector in a single bit yields a code with exactly 12 ones, one in each even/odd pair (`result_word[11:0] ^ result_word[27:16]` is all ones).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_clear | input | 1 | Clear accumulated code and restart the sector |
| ecc_enable | input | 1 | Accumulate incoming beats while high |
| wide_mode | input | 1 | 1: 16-bit beats, 0: 8-bit beats |
| sector_hw_m1 | input | 8 | Sector length in halfwords, minus one |
| beat_valid | input | 1 | Data beat strobe |
| beat_data | input | 16 | Beat data, low byte first |
| result_word | output | 32 | Even parities in bits 11:0, odd parities in bits 27:16 |
| packed_code | output | 24 | Three-byte spare-area form of the code |
| result_valid | output | 1 | Sector fully consumed since the last clear |

## Verification
The assertions take for granted that `wide_mode` and `sector_hw_m1` hold steady between a clear and the completion of the sector. A length or width change in mid-sector has no defined byte position. The stimulus programs both fields only next to a clear pulse. It varies the data, the enable, and the gaps in the strobe, but never the framing. Clear is also driven together with a live beat, to exercise its priority.

// File: rtl/nand_par_pkg.sv
package nand_par_pkg;

    localparam int RESULT_W  = 32;
    localparam int ODD_BASE  = 16;
    localparam int BIT_PAIRS = 3;
    localparam int PACK_W    = 24;

    // Selects the bits of a byte that feed one column parity member.
    function automatic logic [7:0] column_mask(input int stride_idx, input logic odd_half);
        logic [7:0] m;
        for (int b = 0; b < 8; b++) begin
            m[b] = (((b >> stride_idx) & 1) != 0) ? odd_half : ~odd_half;
        end
        return m;
    endfunction

endpackage

// File: rtl/nand_par_byte_term.sv
module nand_par_byte_term #(
    parameter int ADDR_W = 9,
    localparam int NPAIR = nand_par_pkg::BIT_PAIRS + ADDR_W
) (
    input  logic              en_i,
    input  logic [7:0]        data_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NPAIR-1:0]  even_o,
    output logic [NPAIR-1:0]  odd_o
);
    import nand_par_pkg::*;

    logic row_par;
    assign row_par = ^data_i;

    // column parities: stride 1, 2, 4 bits inside the byte
    for (genvar k = 0; k < BIT_PAIRS; k++) begin : g_col
        assign even_o[k] = en_i & (^(data_i & column_mask(k, 1'b0)));
        assign odd_o[k]  = en_i & (^(data_i & column_mask(k, 1'b1)));
    end

    // line parities: one pair per byte address bit
    for (genvar j = 0; j < ADDR_W; j++) begin : g_line
        assign even_o[BIT_PAIRS+j] = en_i & row_par & ~addr_i[j];
        assign odd_o[BIT_PAIRS+j]  = en_i & row_par &  addr_i[j];
    end

endmodule

// File: rtl/nand_par_pack.sv
module nand_par_pack #(
    parameter int ADDR_W = 9,
    localparam int NPAIR = nand_par_pkg::BIT_PAIRS + ADDR_W
) (
    input  logic [NPAIR-1:0]                    even_i,
    input  logic [NPAIR-1:0]                    odd_i,
    output logic [nand_par_pkg::RESULT_W-1:0]   word_o,
    output logic [nand_par_pkg::PACK_W-1:0]     packed_o
);
    import nand_par_pkg::*;

    always_comb begin
        word_o                  = '0;
        word_o[NPAIR-1:0]       = even_i;
        word_o[ODD_BASE +: NPAIR] = odd_i;
    end

    // byte 2 mixes the high even nibble (low) with the high odd nibble (high)
    always_comb begin
        packed_o[7:0]   = word_o[7:0];
        packed_o[15:8]  = word_o[23:16];
        packed_o[19:16] = word_o[11:8];
        packed_o[23:20] = word_o[27:24];
    end

endmodule

// File: rtl/nand_parity_gen.sv
module nand_parity_gen #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_clear,
    input  logic              ecc_enable,
    input  logic              wide_mode,
    input  logic [ADDR_W-2:0] sector_hw_m1,
    input  logic              beat_valid,
    input  logic [15:0]       beat_data,
    output logic [31:0]       result_word,
    output logic [23:0]       packed_code,
    output logic              result_valid
);
    import nand_par_pkg::*;

    localparam int NPAIR = BIT_PAIRS + ADDR_W;
    localparam int CNT_W = ADDR_W + 1;
    localparam int LANES = 2;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [NPAIR-1:0] even;
        logic [NPAIR-1:0] odd;
        logic             done;
    } acc_t;

    acc_t st_q, st_d;

    logic [CNT_W-1:0]  limit;
    logic              room0, room1, accept;
    logic [LANES-1:0]  lane_en;
    logic [7:0]        lane_data [LANES];
    logic [ADDR_W-1:0] lane_addr [LANES];
    logic [NPAIR-1:0]  lane_even [LANES];
    logic [NPAIR-1:0]  lane_odd  [LANES];

    assign limit  = (CNT_W'(sector_hw_m1) + CNT_W'(1)) << 1;
    assign room0  = st_q.count < limit;
    assign room1  = (st_q.count + CNT_W'(1)) < limit;
    assign accept = ecc_enable & beat_valid & ~st_q.done & room0;

    assign lane_en[0] = accept;
    assign lane_en[1] = accept & wide_mode & room1;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_data[i] = beat_data[8*i +: 8];
        assign lane_addr[i] = st_q.count[ADDR_W-1:0] + ADDR_W'(i);

        nand_par_byte_term #(.ADDR_W(ADDR_W)) u_term (
            .en_i   (lane_en[i]),
            .data_i (lane_data[i]),
            .addr_i (lane_addr[i]),
            .even_o (lane_even[i]),
            .odd_o  (lane_odd[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (ecc_clear) begin
            st_d = '0;
        end else if (accept) begin
            st_d.even  = st_q.even ^ lane_even[0] ^ lane_even[1];
            st_d.odd   = st_q.odd  ^ lane_odd[0]  ^ lane_odd[1];
            st_d.count = st_q.count + (lane_en[1] ? CNT_W'(2) : CNT_W'(1));
            st_d.done  = st_d.count >= limit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    nand_par_pack #(.ADDR_W(ADDR_W)) u_pack (
        .even_i   (st_q.even),
        .odd_i    (st_q.odd),
        .word_o   (result_word),
        .packed_o (packed_code)
    );

    assign result_valid = st_q.done;

endmodule

// File: rtl/nand_parity_gen_sva.sv
module nand_parity_gen_sva #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ecc_clear,
    input logic              ecc_enable,
    input logic              beat_valid,
    input logic [31:0]       result_word,
    input logic              result_valid
);

    assert_clear_zeroes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_clear |=> (result_word == 32'h0 && !result_valid));

    assert_disabled_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_clear && !ecc_enable) |=> ($stable(result_word) && $stable(result_valid)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_clear && !beat_valid) |=> ($stable(result_word) && $stable(result_valid)));

    assert_frozen_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !ecc_clear) |=> (result_valid && $stable(result_word)));

    assert_valid_needs_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) |-> $past(beat_valid && ecc_enable && !ecc_clear));

endmodule

bind nand_parity_gen nand_parity_gen_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .ecc_clear    (ecc_clear),
    .ecc_enable   (ecc_enable),
    .beat_valid   (beat_valid),
    .result_word  (result_word),
    .result_valid (result_valid)
);

// File: tb/nand_parity_gen_bench.sv
`timescale 1ns/1ps
module nand_parity_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        en = 1'b0;
    logic        wide = 1'b0;
    logic [7:0]  size = 8'd0;
    logic        bv = 1'b0;
    logic [15:0] bd = 16'h0;
    logic [31:0] result_word;
    logic [23:0] packed_code;
    logic        result_valid;

    int    n_checks = 0;
    int    n_err = 0;
    bit    cmp_on = 1'b0;
    string cur_tag = "R2";

    logic [31:0] m_res = 32'h0;
    int          m_cnt = 0;
    bit          m_valid = 1'b0;

    always #2 clk = ~clk;

    nand_parity_gen u_nand_parity_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .ecc_clear    (clr),
        .ecc_enable   (en),
        .wide_mode    (wide),
        .sector_hw_m1 (size),
        .beat_valid   (bv),
        .beat_data    (bd),
        .result_word  (result_word),
        .packed_code  (packed_code),
        .result_valid (result_valid)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference: accumulate one byte at address a (R2, R3)
    task automatic mdl_byte(input int a, input logic [7:0] d);
        for (int b = 0; b < 8; b++) begin
            if (d[b]) begin
                for (int k = 0; k < 3; k++) begin
                    if (((b >> k) & 1) != 0) m_res[16 + k] = ~m_res[16 + k];
                    else                     m_res[k]      = ~m_res[k];
                end
                for (int j = 0; j < 9; j++) begin
                    if (((a >> j) & 1) != 0) m_res[19 + j] = ~m_res[19 + j];
                    else                     m_res[3 + j]  = ~m_res[3 + j];
                end
            end
        end
    endtask

    always @(posedge clk) begin
        int lim;
        lim = 2 * (int'(size) + 1);
        if (!rst_n) begin
            m_res = 32'h0; m_cnt = 0; m_valid = 1'b0;
        end else if (clr) begin
            m_res = 32'h0; m_cnt = 0; m_valid = 1'b0;
        end else if (en && bv && !m_valid && m_cnt < lim) begin
            mdl_byte(m_cnt, bd[7:0]);
            m_cnt++;
            if (wide && m_cnt < lim) begin
                mdl_byte(m_cnt, bd[15:8]);
                m_cnt++;
            end
            m_valid = (m_cnt >= lim);
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(result_word === m_res, cur_tag, result_word, m_res);
            chk(result_valid === m_valid, "R6 valid", {31'h0, result_valid}, {31'h0, m_valid});
            chk(packed_code === {m_res[27:24], m_res[11:8], m_res[23:16], m_res[7:0]}, "R8",
                {8'h0, packed_code}, {8'h0, m_res[27:24], m_res[11:8], m_res[23:16], m_res[7:0]});
        end
    end

    task automatic drive(input bit v, input logic [15:0] d);
        bv = v; bd = d;
        @(negedge clk);
        bv = 1'b0;
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        chk(result_word == 32'h0 && packed_code == 24'h0 && !result_valid, "R1 reset",
            result_word, 32'h0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);

        // full 512-byte narrow sector with disabled and idle beats (R2 R3 R5)
        size = 8'd255; wide = 1'b0; en = 1'b1;
        do_clear();
        for (int i = 0; i < 512; i++) begin
            if (i % 37 == 5) begin
                cur_tag = "R5"; en = 1'b0;
                drive(1'b1, 16'h00A5);
                en = 1'b1; drive(1'b0, 16'h00FF);
                cur_tag = "R3";
            end
            drive(1'b1, {8'h0, 8'(i * 7 + 3)});
        end
        chk(result_valid, "R6 full sector valid", {31'h0, result_valid}, 32'h1);
        snap = result_word;
        cur_tag = "R6";
        for (int i = 0; i < 3; i++) drive(1'b1, 16'hFFFF);
        chk(result_word == snap, "R6 frozen", result_word, snap);

        // wide sector of random halfwords (R7)
        cur_tag = "R7"; wide = 1'b1;
        do_clear();
        for (int i = 0; i < 256; i++) drive(1'b1, 16'($urandom));
        chk(result_valid, "R7 wide sector valid", {31'h0, result_valid}, 32'h1);

        // smallest wide sector: low byte at address 0, high byte at address 1 (R7)
        size = 8'd0;
        do_clear();
        drive(1'b1, 16'h0100);
        chk(result_word == 32'h00080FF7, "R7 byte order", result_word, 32'h00080FF7);
        chk(result_valid, "R6 one-beat sector", {31'h0, result_valid}, 32'h1);

        // valid timing on an 8-byte narrow sector (R6)
        cur_tag = "R6"; wide = 1'b0; size = 8'd3;
        do_clear();
        for (int i = 0; i < 7; i++) drive(1'b1, 16'h0011 + 16'(i));
        chk(!result_valid, "R6 not yet valid", {31'h0, result_valid}, 32'h0);
        drive(1'b1, 16'h0077);
        chk(result_valid, "R6 valid on last byte", {31'h0, result_valid}, 32'h1);

        // single-bit sector: byte 5 bit 3 (R9)
        cur_tag = "R9"; size = 8'd7;
        do_clear();
        for (int i = 0; i < 16; i++) drive(1'b1, (i == 5) ? 16'h0008 : 16'h0000);
        chk(result_word == 32'h002B0FD4, "R9 single bit code", result_word, 32'h002B0FD4);
        chk($countones(result_word) == 12, "R9 twelve ones", $countones(result_word), 12);
        chk((result_word[11:0] ^ result_word[27:16]) == 12'hFFF, "R9 one per pair",
            {20'h0, result_word[11:0] ^ result_word[27:16]}, 32'hFFF);

        // clear wins over a same-cycle beat, position restarts (R4)
        cur_tag = "R4";
        for (int i = 0; i < 3; i++) drive(1'b1, 16'h00C3);
        clr = 1'b1;
        drive(1'b1, 16'h00FF);
        clr = 1'b0;
        chk(result_word == 32'h0 && !result_valid, "R4 clear priority", result_word, 32'h0);
        drive(1'b1, 16'h0001);
        chk(result_word == 32'h00000FFF, "R4 restart at address 0", result_word, 32'h00000FFF);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule